// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic core of a small 8-bit processor. It holds the accumulator internally: the accumulator is always the first operand, the second operand arrives on an input port, and the result is written back into the accumulator. On every executed operation it also updates four condition flags: carry, zero, sign and parity. Conditional jump logic elsewhere in the processor tests these flags, so they stay registered until the next operation that updates them.

An operation is carried out only in a cycle where the execute enable is high. The accumulator and the flags then change together on the next rising clock edge. One shared adder handles addition, subtraction and compare. A logic unit handles AND, OR, XOR and load. A shift unit handles single-bit shifts and rotates through the carry input. Compare updates only the flags. Reserved operation codes change nothing.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, acc_o is 0, flags_o is 0 and wb_o is 0.
- R2: Code 0 (add) writes A+B and code 1 (add with carry) writes A+B+cin_i, both modulo 256. The carry flag is the carry out of bit 7.
- R3: Code 2 (subtract) writes A-B and code 3 (subtract with borrow) writes A-B-cin_i, both modulo 256. The carry flag is 1 exactly when a borrow occurs, i.e. when A < B (+cin_i).
- R4: Codes 4, 5, 6 and 7 write A AND B, A OR B, A XOR B and B. Each of them clears the carry flag.
- R5: Code 8 shifts A left by one and code 9 shifts A right by one, filling with 0. The carry flag receives the bit shifted out (bit 7 for left, bit 0 for right).
- R6: Code 10 rotates left with cin_i entering bit 0, and code 11 rotates right with cin_i entering bit 7. The carry flag receives the bit that leaves.
- R7: The zero flag (flags_o bit 1) is 1 exactly when all 8 result bits are 0. The sign flag (flags_o bit 2) equals result bit 7. The carry flag is flags_o bit 0.
- R8: The parity flag (flags_o bit 3) is 1 exactly when the result has an even number of 1 bits.
- R9: Code 12 (compare) sets the flags as subtract would, leaves the accumulator unchanged and keeps wb_o low.
- R10: When exec_i is low, the accumulator and flags keep their values and wb_o is low on the next cycle.
- R11: Codes 13 to 15 with exec_i high change neither the accumulator nor the flags, and wb_o is low on the next cycle.
- R12: The accumulator and the flags are updated on the same rising edge that follows an executed operation. wb_o is high for exactly the cycle after an executed operation that writes the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute enable for the operation on op_i |
| op_i | input | 4 | Operation code |
| opb_i | input | 8 | Second operand B |
| cin_i | input | 1 | Carry input for add with carry, subtract with borrow and rotates |
| acc_o | output | 8 | Accumulator (result) |
| wb_o | output | 1 | High in the cycle after the accumulator was written |
| flags_o | output | 4 | Flags: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 parity |

## Verification
A single result can set the carry flag and the zero flag on the same edge. An add that wraps to exactly zero (0x80 + 0x80) does this, and so does a left shift of 0x80. Such a result must also show parity set and sign clear. The bench provokes both cases on purpose and then runs a long pseudo-random sequence that mixes all codes with idle cycles. After every vector it compares the full flag vector, the accumulator and the write-back strobe against an independent model. A flag taken from the wrong source in such a cycle therefore shows up as a miscompare.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_BITS = 4;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_LD  = 4'd7,
      OP_SHL = 4'd8,
      OP_SHR = 4'd9,
      OP_RLC = 4'd10,
      OP_RRC = 4'd11,
      OP_CMP = 4'd12
   } alu_op_e;

   // packed so that cry lands in bit 0 and par in bit 3
   typedef struct packed {
      logic par;
      logic sgn;
      logic zro;
      logic cry;
   } alu_flags_t;

   typedef enum logic [1:0] {
      SEL_ARITH = 2'd0,
      SEL_LOGIC = 2'd1,
      SEL_SHIFT = 2'd2
   } unit_sel_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         cy_o
);

   logic [W-1:0] b_eff;
   logic         c_in;
   logic         c_raw;

   // subtract as A + ~B + ~borrow_in; raw carry then means "no borrow"
   assign b_eff = sub_i ? ~b_i : b_i;
   assign c_in  = sub_i ? ~cin_i : cin_i;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = c_in;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign res_o[i]  = a_i[i] ^ b_eff[i] ^ c[i];
            assign c[i+1]    = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
         end
         assign c_raw = c[W];
      end else begin : g_behav
         assign {c_raw, res_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_in};
      end
   endgenerate

   assign cy_o = sub_i ? ~c_raw : c_raw;

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   fn_i,
   output logic [W-1:0] res_o
);

   always_comb begin
      unique case (fn_i)
         2'd0:    res_o = a_i & b_i;
         2'd1:    res_o = a_i | b_i;
         2'd2:    res_o = a_i ^ b_i;
         default: res_o = b_i;
      endcase
   end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic         right_i,
   input  logic         fill_i,
   output logic [W-1:0] res_o,
   output logic         out_o
);

   always_comb begin
      if (right_i) begin
         res_o = {fill_i, a_i[W-1:1]};
         out_o = a_i[0];
      end else begin
         res_o = {a_i[W-2:0], fill_i};
         out_o = a_i[W-1];
      end
   end

endmodule

// File: rtl/acc_alu_flag_gen.sv
module acc_alu_flag_gen
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] res_i,
   input  logic         cy_i,
   output alu_flags_t   flg_o
);

   assign flg_o.cry = cy_i;
   assign flg_o.zro = ~|res_i;
   assign flg_o.sgn = res_i[W-1];
   assign flg_o.par = ~^res_i;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W          = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_i,
   input  logic [OP_BITS-1:0] op_i,
   input  logic [W-1:0]       opb_i,
   input  logic               cin_i,
   output logic [W-1:0]       acc_o,
   output logic               wb_o,
   output logic [3:0]         flags_o
);

   generate
      if (W < 4) begin : g_bad_width
         $error("acc_alu: W must be at least 4");
      end
   endgenerate

   logic [W-1:0] acc_q;
   alu_flags_t   flg_q;
   logic         wb_q;

   unit_sel_e    sel;
   logic         sub, use_cin, right, rot, wr_acc, wr_flg;
   logic [1:0]   fn;

   always_comb begin
      sel     = SEL_ARITH;
      sub     = 1'b0;
      use_cin = 1'b0;
      fn      = op_i[1:0];
      right   = op_i[0];
      rot     = op_i[1];
      wr_acc  = 1'b0;
      wr_flg  = 1'b0;
      case (op_i)
         OP_ADD: begin wr_acc = 1'b1; wr_flg = 1'b1; end
         OP_ADC: begin use_cin = 1'b1; wr_acc = 1'b1; wr_flg = 1'b1; end
         OP_SUB: begin sub = 1'b1; wr_acc = 1'b1; wr_flg = 1'b1; end
         OP_SBB: begin sub = 1'b1; use_cin = 1'b1; wr_acc = 1'b1; wr_flg = 1'b1; end
         OP_CMP: begin sub = 1'b1; wr_flg = 1'b1; end
         OP_AND, OP_OR, OP_XOR, OP_LD: begin
            sel = SEL_LOGIC; wr_acc = 1'b1; wr_flg = 1'b1;
         end
         OP_SHL, OP_SHR, OP_RLC, OP_RRC: begin
            sel = SEL_SHIFT; wr_acc = 1'b1; wr_flg = 1'b1;
         end
         default: ;
      endcase
   end

   logic [W-1:0] arith_res, logic_res, shift_res, res;
   logic         arith_cy, shift_cy, cy;
   alu_flags_t   flg_new;

   acc_alu_addsub #(.W(W), .RIPPLE(RIPPLE_ADD)) u_addsub (
      .a_i   (acc_q),
      .b_i   (opb_i),
      .cin_i (use_cin & cin_i),
      .sub_i (sub),
      .res_o (arith_res),
      .cy_o  (arith_cy)
   );

   acc_alu_logic #(.W(W)) u_logic (
      .a_i   (acc_q),
      .b_i   (opb_i),
      .fn_i  (fn),
      .res_o (logic_res)
   );

   acc_alu_shift #(.W(W)) u_shift (
      .a_i     (acc_q),
      .right_i (right),
      .fill_i  (rot & cin_i),
      .res_o   (shift_res),
      .out_o   (shift_cy)
   );

   always_comb begin
      case (sel)
         SEL_LOGIC: begin res = logic_res; cy = 1'b0;     end
         SEL_SHIFT: begin res = shift_res; cy = shift_cy; end
         default:   begin res = arith_res; cy = arith_cy; end
      endcase
   end

   acc_alu_flag_gen #(.W(W)) u_flags (
      .res_i (res),
      .cy_i  (cy),
      .flg_o (flg_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         flg_q <= '0;
         wb_q  <= 1'b0;
      end else begin
         wb_q <= exec_i & wr_acc;
         if (exec_i && wr_acc) acc_q <= res;
         if (exec_i && wr_flg) flg_q <= flg_new;
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = flg_q;
   assign wb_o    = wb_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               exec_i,
   input logic [OP_BITS-1:0] op_i,
   input logic [W-1:0]       acc_o,
   input logic               wb_o,
   input logic [3:0]         flags_o
);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(acc_o) && $stable(flags_o) && !wb_o);

   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i > 4'd12) |=> $stable(acc_o) && $stable(flags_o) && !wb_o);

   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_o |-> flags_o[1] == (acc_o == '0));

   p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_o |-> flags_o[2] == acc_o[W-1]);

   p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_o |-> flags_o[3] == ~^acc_o);

   p_cmp_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == OP_CMP) |=> $stable(acc_o) && !wb_o);

   p_logic_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i >= 4'd4 && op_i <= 4'd7) |=> !flags_o[0] && wb_o);

   p_shl_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == OP_SHL) |=> flags_o[0] == $past(acc_o[W-1]));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .exec_i  (exec_i),
   .op_i    (op_i),
   .acc_o   (acc_o),
   .wb_o    (wb_o),
   .flags_o (flags_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       exec_i;
   logic [3:0] op_i;
   logic [7:0] opb_i;
   logic       cin_i;
   logic [7:0] acc_o;
   logic       wb_o;
   logic [3:0] flags_o;

   int  n_vec  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   logic [12:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  m_acc = '0;
   logic [3:0]  m_fl  = '0;

   always #10 clk = ~clk;

   acc_alu u_dut (
      .clk (clk), .rst_n (rst_n), .exec_i (exec_i), .op_i (op_i),
      .opb_i (opb_i), .cin_i (cin_i), .acc_o (acc_o), .wb_o (wb_o),
      .flags_o (flags_o)
   );

   // independent reference: returns {wb, flags[3:0], acc[7:0]}
   function automatic logic [12:0] model(input logic ex, input logic [3:0] op,
      input logic [7:0] a, input logic [7:0] b, input logic ci, input logic [3:0] fl);
      int         ai = int'(a);
      int         bi = int'(b);
      int         ri = 0;
      logic [7:0] r  = a;
      logic       c  = 1'b0;
      logic       wa = 1'b1;
      logic       wf = 1'b1;
      case (op)
         4'd0:  begin ri = ai + bi;      r = ri[7:0]; c = ri > 255; end
         4'd1:  begin ri = ai + bi + ci; r = ri[7:0]; c = ri > 255; end
         4'd2:  begin ri = ai - bi;      r = ri[7:0]; c = ai < bi; end
         4'd3:  begin ri = ai - bi - ci; r = ri[7:0]; c = ai < bi + ci; end
         4'd4:  r = a & b;
         4'd5:  r = a | b;
         4'd6:  r = a ^ b;
         4'd7:  r = b;
         4'd8:  begin r = {a[6:0], 1'b0}; c = a[7]; end
         4'd9:  begin r = {1'b0, a[7:1]}; c = a[0]; end
         4'd10: begin r = {a[6:0], ci};   c = a[7]; end
         4'd11: begin r = {ci, a[7:1]};   c = a[0]; end
         4'd12: begin ri = ai - bi; r = ri[7:0]; c = ai < bi; wa = 1'b0; end
         default: begin wa = 1'b0; wf = 1'b0; end
      endcase
      if (!ex) begin wa = 1'b0; wf = 1'b0; end
      return {wa, (wf ? {~^r, r[7], r == 8'h00, c} : fl), (wa ? r : a)};
   endfunction

   task automatic drive(input logic ex, input logic [3:0] op, input logic [7:0] b,
                        input logic ci, input string tag);
      logic [12:0] e;
      @(negedge clk);
      exec_i = ex; op_i = op; opb_i = b; cin_i = ci;
      e = model(ex, op, m_acc, b, ci, m_fl);
      m_acc = e[7:0];
      m_fl  = e[11:8];
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compares one expected item per edge after the driving edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [12:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({wb_o, flags_o, acc_o} !== e) begin
               n_fail++;
               $display("FAIL %s: got wb=%b flags=%b acc=%h, expected wb=%b flags=%b acc=%h",
                        t, wb_o, flags_o, acc_o, e[12], e[11:8], e[7:0]);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got hang, expected completion");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      rst_n = 1'b0; exec_i = 1'b0; op_i = '0; opb_i = '0; cin_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if ({wb_o, flags_o, acc_o} !== 13'd0) begin
         n_fail++;
         $display("FAIL R1: got wb=%b flags=%b acc=%h, expected all zero", wb_o, flags_o, acc_o);
      end
      rst_n = 1'b1;

      drive(1, 4'd7, 8'h80, 0, "R4 load");
      drive(1, 4'd0, 8'h80, 0, "R2 R7 R8 add wraps to zero with carry");
      drive(1, 4'd7, 8'h3C, 0, "R4 load");
      drive(1, 4'd0, 8'h0F, 0, "R2 add");
      drive(1, 4'd1, 8'hB4, 1, "R2 add with carry");
      drive(1, 4'd7, 8'h10, 0, "R4 load");
      drive(1, 4'd2, 8'h20, 0, "R3 subtract borrow");
      drive(1, 4'd3, 8'h0F, 1, "R3 subtract with borrow");
      drive(1, 4'd12, 8'hFF, 0, "R9 compare");
      drive(1, 4'd12, 8'h00, 0, "R9 compare no borrow");
      drive(1, 4'd4, 8'h0F, 0, "R4 and");
      drive(1, 4'd5, 8'hF0, 0, "R4 or");
      drive(1, 4'd6, 8'hFF, 0, "R4 xor");
      drive(1, 4'd7, 8'h80, 0, "R4 load");
      drive(1, 4'd8, 8'h00, 1, "R5 R7 shift left out of bit 7");
      drive(1, 4'd7, 8'h81, 0, "R4 load");
      drive(1, 4'd9, 8'h00, 1, "R5 shift right");
      drive(1, 4'd10, 8'h00, 1, "R6 rotate left through cin");
      drive(1, 4'd11, 8'h00, 1, "R6 rotate right through cin");
      drive(0, 4'd0, 8'h55, 1, "R10 idle");
      drive(1, 4'd13, 8'h55, 1, "R11 reserved");
      drive(1, 4'd15, 8'hAA, 0, "R11 reserved");
      drive(1, 4'd0, 8'h01, 0, "R12 write strobe");

      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         drive(lf[15:13] != 3'd0, lf[3:0], lf[11:4], lf[12], "R12 random mix");
      end

      @(negedge clk);
      exec_i = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule